// File: doc/BRIEF.md
# Sequential Multiply/Divide Unit with Hi/Lo Result Registers

This block computes 32x32 products and 32/32 quotients one bit per clock, for a processor that keeps these results apart from its general register file. A single start pulse, carrying a 2-bit operation code and two operands, launches one operation. The unit raises `busy` for the whole run. It then writes both result registers at once and pulses `done` for one cycle.

A multiply places the upper half of the 64-bit product in the Hi register and the lower half in the Lo register. A divide places the remainder in Hi and the quotient in Lo. Both registers are always visible on read ports, so move-from-Hi and move-from-Lo reads are plain wire reads. The signed operations take operand magnitudes, run the unsigned shift-add or restoring algorithm, and then correct the signs. No operation reports overflow. A zero divisor still completes, and it leaves defined values in Hi and Lo.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset, `hi_q` and `lo_q` are zero and `busy` and `done` are low.
- R2: Operation code 2'b00 is a signed multiply: {`hi_q`,`lo_q`} becomes the 64-bit two's-complement product of `opa` and `opb`.
- R3: Operation code 2'b01 is an unsigned multiply: {`hi_q`,`lo_q`} becomes the 64-bit unsigned product.
- R4: Operation code 2'b10 is a signed divide with a nonzero divisor. `lo_q` gets the quotient truncated toward zero, and `hi_q` gets the remainder, which carries the sign of the dividend.
- R5: Operation code 2'b11 is an unsigned divide with a nonzero divisor. `lo_q` gets the quotient and `hi_q` gets the remainder.
- R6: A divide whose divisor is zero, signed or unsigned, completes normally. It leaves `lo_q` all ones and `hi_q` equal to the dividend.
- R7: `start` is taken only while `busy` is low, and `busy` is high in the next cycle. `done` is high for exactly one cycle, WIDTH+2 clock cycles after the accepting edge, and `busy` is low in that cycle.
- R8: A `start` pulse that arrives while `busy` is high is ignored. The results are those of the operation already running.
- R9: `hi_q` and `lo_q` change only in the cycle in which `done` is high. They hold between operations and for the whole of a run.
- R10: No overflow is flagged and nothing wraps into an error. The signed divide of the most negative value by -1 gives `lo_q` = 32'h8000_0000 and `hi_q` = 0. The signed square of the most negative value gives `hi_q` = 32'h4000_0000 and `lo_q` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch request, sampled while idle |
| op | input | 2 | Operation: 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| opa | input | WIDTH | Multiplicand or dividend |
| opb | input | WIDTH | Multiplier or divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| hi_q | output | WIDTH | Hi register: upper product half or remainder |
| lo_q | output | WIDTH | Lo register: lower product half or quotient |

## Verification
On every cycle the assertions check these properties:
- `done` is a single-cycle pulse that closes a busy period.
- Hi and Lo never change outside the `done` cycle.
- A start request that arrives mid-run cannot alter the latched sign and operation flags.
- Each restoring step against a zero divisor always produces a quotient bit of one.

Only the bench scenarios can show the arithmetic values. These cover signed and unsigned products and quotients over random operands, and the sign rules for the remainder. They also cover the two most-negative-value corner cases, the zero-divisor results, and the exact completion latency.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

   // bit 1 selects divide, bit 0 selects unsigned
   typedef enum logic [1:0] {
      OP_MUL_S = 2'b00,
      OP_MUL_U = 2'b01,
      OP_DIV_S = 2'b10,
      OP_DIV_U = 2'b11
   } md_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_RUN  = 2'b01,
      ST_FIN  = 2'b10
   } md_state_e;

endpackage

// File: rtl/muldiv_mag.sv
module muldiv_mag #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] val,
   input  logic             is_signed,
   output logic [WIDTH-1:0] mag,
   output logic             neg
);
   assign neg = is_signed & val[WIDTH-1];
   assign mag = neg ? (~val + 1'b1) : val;
endmodule

// File: rtl/muldiv_iter.sv
module muldiv_iter #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic             is_div,
   input  logic [WIDTH-1:0] a_mag,
   input  logic [WIDTH-1:0] b_mag,
   output logic [WIDTH-1:0] hi_r,
   output logic [WIDTH-1:0] lo_r
);
   logic [WIDTH-1:0] dvsr_r;

   // shift-add multiply step
   logic [WIDTH:0]   add_sum;
   logic [WIDTH-1:0] mul_hi_n, mul_lo_n;
   assign add_sum  = {1'b0, hi_r} + (lo_r[0] ? {1'b0, dvsr_r} : '0);
   assign mul_hi_n = add_sum[WIDTH:1];
   assign mul_lo_n = {add_sum[0], lo_r[WIDTH-1:1]};

   // restoring divide step
   logic [WIDTH:0]   shifted;
   logic [WIDTH+1:0] diff;
   logic             fits;
   logic [WIDTH-1:0] div_hi_n, div_lo_n;
   assign shifted  = {hi_r, lo_r[WIDTH-1]};
   assign diff     = {1'b0, shifted} - {2'b00, dvsr_r};
   assign fits     = ~diff[WIDTH+1];
   assign div_hi_n = fits ? diff[WIDTH-1:0] : shifted[WIDTH-1:0];
   assign div_lo_n = {lo_r[WIDTH-2:0], fits};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_r   <= '0;
         lo_r   <= '0;
         dvsr_r <= '0;
      end else if (load) begin
         hi_r   <= '0;
         lo_r   <= a_mag;
         dvsr_r <= b_mag;
      end else if (step) begin
         hi_r <= is_div ? div_hi_n : mul_hi_n;
         lo_r <= is_div ? div_lo_n : mul_lo_n;
      end
   end

   // R6
   zero_dvsr_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && is_div && dvsr_r == '0) |=> lo_r[0]);
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
   import muldiv_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [1:0]       op,
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   output logic             busy,
   output logic             done,
   output logic [WIDTH-1:0] hi_q,
   output logic [WIDTH-1:0] lo_q
);
   localparam int CW = $clog2(WIDTH + 1);

   generate
      if (WIDTH < 4) begin : g_width_bad
         $error("muldiv_hilo: WIDTH must be at least 4");
      end
   endgenerate

   md_state_e        state;
   logic [CW-1:0]    cnt;
   logic             is_div_q, neg_prod_q, neg_lo_q, neg_hi_q;
   logic             load, step, op_signed;
   logic [WIDTH-1:0] a_mag, b_mag, hi_r, lo_r;
   logic             a_neg, b_neg;

   assign op_signed = ~op[0];
   assign load      = start && (state == ST_IDLE);
   assign step      = (state == ST_RUN);
   assign busy      = (state != ST_IDLE);

   muldiv_mag #(.WIDTH(WIDTH)) u_mag_a (
      .val(opa), .is_signed(op_signed), .mag(a_mag), .neg(a_neg));
   muldiv_mag #(.WIDTH(WIDTH)) u_mag_b (
      .val(opb), .is_signed(op_signed), .mag(b_mag), .neg(b_neg));

   muldiv_iter #(.WIDTH(WIDTH)) u_iter (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step), .is_div(is_div_q),
      .a_mag(a_mag), .b_mag(b_mag), .hi_r(hi_r), .lo_r(lo_r));

   // sign correction of the unsigned result
   logic [2*WIDTH-1:0] prod_fix;
   logic [WIDTH-1:0]   quo_fix, rem_fix;
   assign prod_fix = neg_prod_q ? (~{hi_r, lo_r} + 1'b1) : {hi_r, lo_r};
   assign quo_fix  = neg_lo_q ? (~lo_r + 1'b1) : lo_r;
   assign rem_fix  = neg_hi_q ? (~hi_r + 1'b1) : hi_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cnt        <= '0;
         is_div_q   <= 1'b0;
         neg_prod_q <= 1'b0;
         neg_lo_q   <= 1'b0;
         neg_hi_q   <= 1'b0;
         hi_q       <= '0;
         lo_q       <= '0;
         done       <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: if (start) begin
               is_div_q   <= op[1];
               neg_prod_q <= ~op[1] & (a_neg ^ b_neg);
               neg_lo_q   <= op[1] & (a_neg ^ b_neg) & (opb != '0);
               neg_hi_q   <= op[1] & a_neg;
               cnt        <= '0;
               state      <= ST_RUN;
            end
            ST_RUN: begin
               cnt <= cnt + 1'b1;
               if (cnt == CW'(WIDTH - 1)) state <= ST_FIN;
            end
            ST_FIN: begin
               if (is_div_q) begin
                  hi_q <= rem_fix;
                  lo_q <= quo_fix;
               end else begin
                  hi_q <= prod_fix[2*WIDTH-1:WIDTH];
                  lo_q <= prod_fix[WIDTH-1:0];
               end
               done  <= 1'b1;
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R7
   done_closes_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) && !busy));
   // R8
   flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(is_div_q) && $stable(neg_hi_q) && $stable(neg_lo_q)));
   // R9
   hilo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((hi_q != $past(hi_q)) || (lo_q != $past(lo_q))) |-> done);
endmodule

// File: tb/muldiv_hilo_tb.sv
`timescale 1ns/1ps
module muldiv_hilo_tb;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [1:0]   op = 2'b00;
   logic [W-1:0] opa = '0, opb = '0;
   logic         busy, done;
   logic [W-1:0] hi_q, lo_q;
   int           checks = 0;
   int           errors = 0;

   always #4 clk = ~clk;

   muldiv_hilo #(.WIDTH(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
      .busy(busy), .done(done), .hi_q(hi_q), .lo_q(lo_q));

   function automatic logic [63:0] expect_res(input logic [1:0] o, input logic [31:0] a,
                                              input logic [31:0] b);
      logic signed [63:0] sa, sb, q, r;
      sa = 64'($signed(a));
      sb = 64'($signed(b));
      case (o)
         2'b00: return sa * sb;
         2'b01: return {32'b0, a} * {32'b0, b};
         2'b10: begin
            if (b == 0) return {a, 32'hFFFF_FFFF};
            q = sa / sb;
            r = sa % sb;
            return {r[31:0], q[31:0]};
         end
         default: begin
            if (b == 0) return {a, 32'hFFFF_FFFF};
            return {a % b, a / b};
         end
      endcase
   endfunction

   function automatic string tag_of(input logic [1:0] o, input logic [31:0] b);
      if (o[1] && b == 0) return "R6";
      case (o)
         2'b00: return "R2";
         2'b01: return "R3";
         2'b10: return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic check(input string req, input string what, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // glitch: drive a second start while busy (R8)
   task automatic run_op(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                         input bit glitch, input string req);
      int n;
      logic [63:0] exp, prev;
      exp  = expect_res(o, a, b);
      prev = {hi_q, lo_q};
      @(negedge clk);
      start = 1'b1; op = o; opa = a; opb = b;
      @(posedge clk);
      n = 0;
      forever begin
         @(negedge clk);
         n++;
         start = 1'b0;
         if (n == 1) check("R7", "busy after start", {63'b0, busy}, 64'd1);
         if (glitch && n == 3) begin
            start = 1'b1; op = ~o; opa = ~a; opb = b + 32'd7;
         end
         if (n == 10) check("R9", "hold during run", {hi_q, lo_q}, prev);
         if (done) break;
         if (n > 200) begin
            check("R7", "done timeout", 64'd0, 64'd1);
            finish_run();
         end
      end
      check("R7", "latency", 64'(n), 64'(W + 2));
      check("R7", "busy low at done", {63'b0, busy}, 64'd0);
      check(glitch ? "R8" : req, "hi:lo", {hi_q, lo_q}, exp);
      @(negedge clk);
      check("R7", "done one cycle", {63'b0, done}, 64'd0);
      repeat (3) @(negedge clk);
      check("R9", "hold after done", {hi_q, lo_q}, exp);
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [1:0]  ro;
      logic [31:0] ra, rb;
      void'($urandom(32'd20240917));
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", "reset hi:lo", {hi_q, lo_q}, 64'd0);
      check("R1", "reset busy/done", {62'b0, busy, done}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      run_op(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R2");
      run_op(2'b00, 32'd12345, 32'hFFFF_FF85, 0, "R2");
      run_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R3");
      run_op(2'b10, 32'hFFFF_FFF9, 32'd2, 0, "R4");
      run_op(2'b10, 32'd7, 32'hFFFF_FFFE, 0, "R4");
      run_op(2'b11, 32'hFFFF_FFF9, 32'd2, 0, "R5");
      run_op(2'b10, 32'hFFFF_FFFB, 32'd0, 0, "R6");
      run_op(2'b11, 32'h8765_4321, 32'd0, 0, "R6");
      run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, 0, "R10");
      run_op(2'b00, 32'h8000_0000, 32'h8000_0000, 0, "R10");
      run_op(2'b01, 32'hDEAD_BEEF, 32'h1234_5678, 1, "R8");
      run_op(2'b10, 32'h0000_1000, 32'h0000_0003, 1, "R8");

      for (int i = 0; i < 200; i++) begin
         ro = 2'($urandom);
         ra = $urandom;
         rb = $urandom;
         if (($urandom % 8) == 0) rb = rb >> ($urandom % 32);
         if (($urandom % 20) == 0) rb = 0;
         run_op(ro, ra, rb, 0, tag_of(ro, rb));
      end
      finish_run();
   end
endmodule